// File: doc/BRIEF.md
# Dual-Clock Real-Time Counter

This block keeps a 16-bit counter that advances on every rising edge of a slow, already-prescaled RTC clock. Software on a fast system clock controls it through an 8-bit register port. The counter runs from zero up to a programmable period limit and then wraps back to zero. On every count it is also checked against a programmable match value. When the count hits the match value, or when it wraps at the limit, the block sets an interrupt flag. That flag rises on the count that follows the event. Each flag is cleared either by software writing a one to it or by an acknowledge pulse from the interrupt controller when the vector is taken.

Values written from the system side cross into the RTC domain through a toggle handshake. Only one crossing can be in flight at a time. A busy bit in the status register stays high until the RTC side has taken the value. Commits made while the bit is high are dropped. The 16-bit values are moved through an 8-bit temporary byte. A low-byte write is staged in that byte, and the high-byte write then commits the whole word. A low-byte read latches the matching high byte into the temporary byte, and a high-byte read returns it. Flag events and the count travel back to the system side as toggles through two-stage synchronisers.

Top module: `rtcnt_top`

## Requirements
- R1: After reset the count, both flags, the busy bit, the match value and the period limit are all zero.
- R2: The count rises by one on each RTC rising edge. In the RTC cycle where it equals the period limit, the next edge brings it to zero instead.
- R3: The overflow flag sits in bit 0 of the flag register at address 0x3. It is set at the RTC edge on which the count leaves the period limit, and it is visible on the system side before the following falling RTC edge.
- R4: The match flag sits in bit 1 of the flag register at address 0x3. It is set at the RTC edge that follows an RTC cycle in which the count equals the match value.
- R5: Writing a one to bit 0 or bit 1 of address 0x3 clears that flag. Writing a zero leaves it alone. Bits 7:2 always read zero, and writing ones to them changes nothing.
- R6: A one-cycle pulse on ovf_ack or cmp_ack clears the matching flag. If a new event for that flag lands in the same system cycle, the set wins.
- R7: Writing the low byte (count 0x8, match 0xA, limit 0xC) stores it in the temporary byte at 0x4. Writing the high byte (0x9, 0xB, 0xD) commits {high, temporary}. A committed count shows up on the second RTC rising edge after the commit and keeps counting from there.
- R8: Status bit 0 at address 0x0 is high from the system cycle after a commit until the RTC side has acknowledged, which takes no more than three RTC periods. A high-byte write made while the bit is high is ignored.
- R9: Reading 0x8 (or 0xA, 0xC) with rd_en returns the low byte and latches the matching high byte into the temporary byte. A read of 0x9 (or 0xB, 0xD) returns that latched byte.
- R10: A count above the period limit runs up to 0xFFFF and rolls to zero with no overflow flag.
- R11: A committed match or limit value applies from the second RTC rising edge after the commit, and reading it back returns the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register port and the flags |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| rtc_clk | input | 1 | Prescaled RTC clock |
| rtc_rst_n | input | 1 | Active-low reset, RTC domain |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; updates the temporary byte on low-byte reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| cmp_ack | input | 1 | Vector-taken pulse that clears the match flag |
| ovf_ack | input | 1 | Vector-taken pulse that clears the overflow flag |
| cmp_flag | output | 1 | Match interrupt flag |
| ovf_flag | output | 1 | Overflow interrupt flag |
| rtc_count | output | 16 | Live count, RTC domain |

## Verification
The bench goes after the load latency. A design that loads on the first RTC edge, or on the third, leaves the count one step off on every later comparison. It fires a second commit while the first is still in flight. A design without the busy guard would load the second value or corrupt the first. It parks the count above the period limit and watches the wrap at 0xFFFF, where a design that tests "greater or equal" or flags every wrap would raise overflow in the wrong place. It also writes ones into the reserved flag bits, which must neither clear nor set anything, and it clears one flag at a time to catch a clear that reaches the wrong bit.

// File: rtl/rtcnt_pkg.sv
`timescale 1ns/1ps
package rtcnt_pkg;
    localparam int BYTE_WIDTH = 8;
    localparam int ADDR_WIDTH = 4;

    // register map (word addresses)
    localparam int A_STATUS = 'h0;
    localparam int A_FLAGS  = 'h3;
    localparam int A_TEMP   = 'h4;
    localparam int A_CNT_L  = 'h8;
    localparam int A_CNT_H  = 'h9;
    localparam int A_CMP_L  = 'hA;
    localparam int A_CMP_H  = 'hB;
    localparam int A_TOP_L  = 'hC;
    localparam int A_TOP_H  = 'hD;

    // flag bit positions
    localparam int FLAG_OVF = 0;
    localparam int FLAG_CMP = 1;

    typedef enum logic [1:0] {
        TGT_CNT = 2'd0,
        TGT_CMP = 2'd1,
        TGT_TOP = 2'd2
    } tgt_e;
endpackage

// File: rtl/rtcnt_sync.sv
`timescale 1ns/1ps
module rtcnt_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/rtcnt_core.sv
`timescale 1ns/1ps
module rtcnt_core
    import rtcnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tgl_i,
    input  tgt_e             pend_tgt_i,
    input  logic [CNT_W-1:0] pend_data_i,
    output logic             ack_tgl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pub_tgl_o,
    output logic             cmp_tgl_o,
    output logic             ovf_tgl_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] top;
        logic             req_s1;
        logic             req_s2;
        logic             cmp_tgl;
        logic             ovf_tgl;
        logic             pub_tgl;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     load_w;
    logic     at_top_w;
    logic     at_cmp_w;

    always_comb begin
        st_d     = st_q;
        // request toggle: first stage resolves for a whole slow period
        st_d.req_s1 = req_tgl_i;
        st_d.req_s2 = st_q.req_s1;
        load_w   = st_q.req_s1 ^ st_q.req_s2;
        at_top_w = (st_q.cnt == st_q.top);
        at_cmp_w = (st_q.cnt == st_q.cmp);

        st_d.cnt = at_top_w ? '0 : st_q.cnt + 1'b1;
        if (at_top_w) st_d.ovf_tgl = ~st_q.ovf_tgl;
        if (at_cmp_w) st_d.cmp_tgl = ~st_q.cmp_tgl;
        st_d.pub_tgl = ~st_q.pub_tgl;

        if (load_w) begin
            unique case (pend_tgt_i)
                TGT_CNT: st_d.cnt = pend_data_i;
                TGT_CMP: st_d.cmp = pend_data_i;
                TGT_TOP: st_d.top = pend_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tgl_o = st_q.req_s2;
    assign cnt_o     = st_q.cnt;
    assign pub_tgl_o = st_q.pub_tgl;
    assign cmp_tgl_o = st_q.cmp_tgl;
    assign ovf_tgl_o = st_q.ovf_tgl;

    // R2: plain step below the limit
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_w && !at_top_w) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R3: leaving the limit wraps to zero and signals an overflow event
    a_r3_limit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_w && at_top_w) |=> (cnt_o == '0 && ovf_tgl_o != $past(ovf_tgl_o)));

    // R4: a match cycle produces exactly one event toggle
    a_r4_match_event: assert property (@(posedge clk) disable iff (!rst_n)
        at_cmp_w |=> (cmp_tgl_o != $past(cmp_tgl_o)));

    // R7: a count load shows the pending word
    a_r7_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_w && pend_tgt_i == TGT_CNT) |=> (cnt_o == $past(pend_data_i)));
endmodule

// File: rtl/rtcnt_regs.sv
`timescale 1ns/1ps
module rtcnt_regs
    import rtcnt_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              cmp_ack,
    input  logic              ovf_ack,
    input  logic              ack_s_i,
    input  logic              pub_s_i,
    input  logic              cmp_s_i,
    input  logic              ovf_s_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              req_tgl_o,
    output tgt_e              pend_tgt_o,
    output logic [CNT_W-1:0]  pend_data_o,
    output logic              cmp_flag_o,
    output logic              ovf_flag_o
);
    localparam logic [ADDR_W-1:0] AD_STATUS = ADDR_W'(A_STATUS);
    localparam logic [ADDR_W-1:0] AD_FLAGS  = ADDR_W'(A_FLAGS);
    localparam logic [ADDR_W-1:0] AD_TEMP   = ADDR_W'(A_TEMP);
    localparam logic [ADDR_W-1:0] AD_CNT_L  = ADDR_W'(A_CNT_L);
    localparam logic [ADDR_W-1:0] AD_CNT_H  = ADDR_W'(A_CNT_H);
    localparam logic [ADDR_W-1:0] AD_CMP_L  = ADDR_W'(A_CMP_L);
    localparam logic [ADDR_W-1:0] AD_CMP_H  = ADDR_W'(A_CMP_H);
    localparam logic [ADDR_W-1:0] AD_TOP_L  = ADDR_W'(A_TOP_L);
    localparam logic [ADDR_W-1:0] AD_TOP_H  = ADDR_W'(A_TOP_H);

    typedef struct packed {
        logic [BYTE_W-1:0] tmp;
        logic              req_tgl;
        tgt_e              pend_tgt;
        logic [CNT_W-1:0]  pend_data;
        logic [CNT_W-1:0]  cmp_sh;
        logic [CNT_W-1:0]  top_sh;
        logic [CNT_W-1:0]  snap;
        logic              fl_cmp;
        logic              fl_ovf;
        logic              cmp_prev;
        logic              ovf_prev;
        logic              pub_prev;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    busy_w;
    logic    cmp_set_w, ovf_set_w, pub_new_w;
    logic    hi_wr_w, commit_w;
    logic    cmp_clr_w, ovf_clr_w;

    always_comb begin
        st_d      = st_q;
        busy_w    = st_q.req_tgl ^ ack_s_i;
        cmp_set_w = cmp_s_i ^ st_q.cmp_prev;
        ovf_set_w = ovf_s_i ^ st_q.ovf_prev;
        pub_new_w = pub_s_i ^ st_q.pub_prev;
        st_d.cmp_prev = cmp_s_i;
        st_d.ovf_prev = ovf_s_i;
        st_d.pub_prev = pub_s_i;

        if (pub_new_w) st_d.snap = cnt_i;

        hi_wr_w  = wr_en && (addr == AD_CNT_H || addr == AD_CMP_H || addr == AD_TOP_H);
        commit_w = hi_wr_w && !busy_w;

        // low-byte reads capture the partner byte
        if (rd_en) begin
            unique case (addr)
                AD_CNT_L: st_d.tmp = st_q.snap[CNT_W-1:BYTE_W];
                AD_CMP_L: st_d.tmp = st_q.cmp_sh[CNT_W-1:BYTE_W];
                AD_TOP_L: st_d.tmp = st_q.top_sh[CNT_W-1:BYTE_W];
                default:  ;
            endcase
        end

        if (wr_en) begin
            unique case (addr)
                AD_TEMP, AD_CNT_L, AD_CMP_L, AD_TOP_L: st_d.tmp = wdata;
                default: ;
            endcase
        end

        if (commit_w) begin
            st_d.req_tgl   = ~st_q.req_tgl;
            st_d.pend_data = {wdata, st_q.tmp};
            unique case (addr)
                AD_CMP_H: begin
                    st_d.pend_tgt = TGT_CMP;
                    st_d.cmp_sh   = {wdata, st_q.tmp};
                end
                AD_TOP_H: begin
                    st_d.pend_tgt = TGT_TOP;
                    st_d.top_sh   = {wdata, st_q.tmp};
                end
                default: st_d.pend_tgt = TGT_CNT;
            endcase
        end

        cmp_clr_w = cmp_ack || (wr_en && addr == AD_FLAGS && wdata[FLAG_CMP]);
        ovf_clr_w = ovf_ack || (wr_en && addr == AD_FLAGS && wdata[FLAG_OVF]);
        if (cmp_set_w)      st_d.fl_cmp = 1'b1;
        else if (cmp_clr_w) st_d.fl_cmp = 1'b0;
        if (ovf_set_w)      st_d.fl_ovf = 1'b1;
        else if (ovf_clr_w) st_d.fl_ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            AD_STATUS: rdata[0] = busy_w;
            AD_FLAGS: begin
                rdata[FLAG_CMP] = st_q.fl_cmp;
                rdata[FLAG_OVF] = st_q.fl_ovf;
            end
            AD_TEMP, AD_CNT_H, AD_CMP_H, AD_TOP_H: rdata = st_q.tmp;
            AD_CNT_L: rdata = st_q.snap[BYTE_W-1:0];
            AD_CMP_L: rdata = st_q.cmp_sh[BYTE_W-1:0];
            AD_TOP_L: rdata = st_q.top_sh[BYTE_W-1:0];
            default:  rdata = '0;
        endcase
    end

    assign req_tgl_o   = st_q.req_tgl;
    assign pend_tgt_o  = st_q.pend_tgt;
    assign pend_data_o = st_q.pend_data;
    assign cmp_flag_o  = st_q.fl_cmp;
    assign ovf_flag_o  = st_q.fl_ovf;

    // R5: writing one to the match bit clears it when no event lands
    a_r5_w1c_match: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AD_FLAGS && wdata[FLAG_CMP] && !cmp_set_w) |=> !cmp_flag_o);

    // R6: acknowledge pulse clears the overflow flag
    a_r6_ack_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack && !ovf_set_w) |=> !ovf_flag_o);

    // R6: an arriving event always sets, even against a clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_set_w || ovf_set_w) |=> ((cmp_flag_o || !$past(cmp_set_w)) && (ovf_flag_o || !$past(ovf_set_w))));

    // R8: a commit raises busy, and while busy the pending word holds
    a_r8_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
        commit_w |=> (req_tgl_o != ack_s_i || $past(ack_s_i) != ack_s_i));
    a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr_w && busy_w) |=> ($stable(pend_data_o) && $stable(req_tgl_o)));
endmodule

// File: rtl/rtcnt_top.sv
`timescale 1ns/1ps
module rtcnt_top
    import rtcnt_pkg::*;
#(
    parameter int BYTE_W = BYTE_WIDTH,
    parameter int ADDR_W = ADDR_WIDTH,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              cmp_ack,
    input  logic              ovf_ack,
    output logic              cmp_flag,
    output logic              ovf_flag,
    output logic [CNT_W-1:0]  rtc_count
);
    logic             req_tgl;
    tgt_e             pend_tgt;
    logic [CNT_W-1:0] pend_data;
    logic             ack_tgl, pub_tgl, cmp_tgl, ovf_tgl;
    logic [3:0]       back_s;

    rtcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk         (rtc_clk),
        .rst_n       (rtc_rst_n),
        .req_tgl_i   (req_tgl),
        .pend_tgt_i  (pend_tgt),
        .pend_data_i (pend_data),
        .ack_tgl_o   (ack_tgl),
        .cnt_o       (rtc_count),
        .pub_tgl_o   (pub_tgl),
        .cmp_tgl_o   (cmp_tgl),
        .ovf_tgl_o   (ovf_tgl)
    );

    rtcnt_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk     (sys_clk),
        .rst_n   (sys_rst_n),
        .async_i ({ack_tgl, pub_tgl, cmp_tgl, ovf_tgl}),
        .sync_o  (back_s)
    );

    rtcnt_regs #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (sys_clk),
        .rst_n       (sys_rst_n),
        .addr        (addr),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .wdata       (wdata),
        .rdata       (rdata),
        .cmp_ack     (cmp_ack),
        .ovf_ack     (ovf_ack),
        .ack_s_i     (back_s[3]),
        .pub_s_i     (back_s[2]),
        .cmp_s_i     (back_s[1]),
        .ovf_s_i     (back_s[0]),
        .cnt_i       (rtc_count),
        .req_tgl_o   (req_tgl),
        .pend_tgt_o  (pend_tgt),
        .pend_data_o (pend_data),
        .cmp_flag_o  (cmp_flag),
        .ovf_flag_o  (ovf_flag)
    );
endmodule

// File: tb/tb_rtcnt_top.sv
`timescale 1ns/1ps
module tb_rtcnt_top;
    logic        sys_clk = 1'b0;
    logic        rtc_clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        rtc_rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        cmp_ack = 1'b0;
    logic        ovf_ack = 1'b0;
    logic        cmp_flag, ovf_flag;
    logic [15:0] rtc_count;

    rtcnt_top dut (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .cmp_ack(cmp_ack), .ovf_ack(ovf_ack), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
        .rtc_count(rtc_count)
    );

    always #2.5 sys_clk = ~sys_clk;   // 200 MHz
    always #40  rtc_clk = ~rtc_clk;   // slow prescaled clock

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit running = 1'b0;

    // behavioural reference
    logic [15:0] m_cnt = '0, m_cmp = '0, m_top = '0;
    bit          m_fc = 1'b0, m_fo = 1'b0;
    int          p_cd = 0;
    int          p_tgt = 0;
    logic [15:0] p_val = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge rtc_clk) begin
        if (running) begin
            logic        ev_c, ev_o;
            logic [15:0] nxt;
            ev_c = (m_cnt == m_cmp);
            ev_o = (m_cnt == m_top);
            nxt  = ev_o ? 16'h0 : m_cnt + 16'h1;
            if (p_cd > 0) begin
                p_cd--;
                if (p_cd == 0) begin
                    case (p_tgt)
                        0: nxt   = p_val;
                        1: m_cmp = p_val;
                        default: m_top = p_val;
                    endcase
                end
            end
            m_cnt = nxt;
            if (ev_c) m_fc = 1'b1;
            if (ev_o) m_fo = 1'b1;
        end
    end

    always @(negedge rtc_clk) begin
        #1;
        if (running && !done) begin
            chk("R2 count per RTC edge", rtc_count, m_cnt);
            chk("R4 match flag", cmp_flag, m_fc);
            chk("R3 overflow flag", ovf_flag, m_fo);
        end
    end

    task automatic sync_slot();
        @(negedge rtc_clk);
        #3;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge sys_clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge sys_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input bit latch, output logic [7:0] d);
        @(negedge sys_clk);
        addr = a; rd_en = latch;
        #1 d = rdata;
        @(negedge sys_clk);
        rd_en = 1'b0;
    endtask

    task automatic commit(input logic [3:0] hi, input logic [15:0] val, input bit accept);
        wr(hi - 4'd1, val[7:0]);
        wr(hi, val[15:8]);
        if (accept) begin
            p_tgt = (hi == 4'h9) ? 0 : (hi == 4'hB) ? 1 : 2;
            p_val = val;
            p_cd  = 2;
        end
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        s = 8'h1;
        for (int i = 0; i < 4; i++) begin
            rd(4'h0, 1'b0, s);
            if (s[0] == 1'b0) break;
            sync_slot();
        end
        chk("R8 busy drops after acknowledge", s[0], 1'b0);
    endtask

    task automatic read_count();
        logic [7:0] lo, hi;
        rd(4'h8, 1'b1, lo);
        rd(4'h9, 1'b0, hi);
        chk("R9 sixteen-bit count read", {hi, lo}, m_cnt);
    endtask

    initial begin
        logic [7:0] d;
        #30;
        sys_rst_n = 1'b1;
        rtc_rst_n = 1'b1;
        running   = 1'b1;
        #1;
        chk("R1 reset count", rtc_count, 16'h0);
        chk("R1 reset match flag", cmp_flag, 1'b0);
        chk("R1 reset overflow flag", ovf_flag, 1'b0);
        rd(4'h0, 1'b0, d);
        chk("R1 reset busy", d, 8'h00);

        // reset limit and match are zero: both flags fire at once
        sync_slot();
        rd(4'h3, 1'b0, d);
        chk("R3 R4 flags with zero limit and match", d, {6'b0, m_fc, m_fo});
        rd(4'hC, 1'b1, d);
        chk("R1 reset limit readback", d, 8'h00);

        // period limit 20
        sync_slot();
        commit(4'hD, 16'd20, 1'b1);
        rd(4'h0, 1'b0, d);
        chk("R8 busy after commit", d[0], 1'b1);
        wait_idle();

        // match value 7, read back
        sync_slot();
        commit(4'hB, 16'd7, 1'b1);
        wait_idle();
        sync_slot();
        rd(4'hA, 1'b1, d);
        chk("R11 match low readback", d, 8'd7);
        rd(4'hB, 1'b0, d);
        chk("R11 match high readback", d, 8'd0);

        // clear both flags by writing ones
        sync_slot();
        wr(4'h3, 8'h03);
        m_fc = 1'b0; m_fo = 1'b0;

        for (int i = 0; i < 40 && !m_fc; i++) sync_slot();
        sync_slot();
        wr(4'h3, 8'hFC);
        rd(4'h3, 1'b0, d);
        chk("R5 reserved bits zero and inert", d, {6'b0, m_fc, m_fo});
        wr(4'h3, 8'h02);
        m_fc = 1'b0;
        rd(4'h3, 1'b0, d);
        chk("R5 single-bit clear", d, {6'b0, m_fc, m_fo});

        // acknowledge pulses
        for (int i = 0; i < 40 && !m_fo; i++) sync_slot();
        sync_slot();
        @(negedge sys_clk); ovf_ack = 1'b1;
        @(negedge sys_clk); ovf_ack = 1'b0;
        m_fo = 1'b0;
        #1 chk("R6 overflow cleared by acknowledge", ovf_flag, 1'b0);
        for (int i = 0; i < 40 && !m_fc; i++) sync_slot();
        sync_slot();
        @(negedge sys_clk); cmp_ack = 1'b1;
        @(negedge sys_clk); cmp_ack = 1'b0;
        m_fc = 1'b0;
        #1 chk("R6 match cleared by acknowledge", cmp_flag, 1'b0);

        for (int i = 0; i < 3; i++) begin
            sync_slot();
            read_count();
        end

        // count load with a second commit while busy
        sync_slot();
        commit(4'h9, 16'd15, 1'b1);
        sync_slot();
        commit(4'h9, 16'd3, 1'b0);
        sync_slot();
        chk("R7 count load on second RTC edge", rtc_count, 16'd15);
        wait_idle();
        for (int i = 0; i < 4; i++) sync_slot();
        read_count();

        // count above the limit rolls at 0xFFFF without overflow
        sync_slot();
        commit(4'h9, 16'hFFFD, 1'b1);
        sync_slot();
        sync_slot();
        chk("R7 count load above limit", rtc_count, 16'hFFFD);
        wr(4'h3, 8'h03);
        m_fc = 1'b0; m_fo = 1'b0;
        for (int i = 0; i < 8 && m_cnt != 16'd1; i++) sync_slot();
        chk("R10 count rolled past 0xFFFF", rtc_count, 16'd1);
        chk("R10 no overflow on natural roll", ovf_flag, 1'b0);
        for (int i = 0; i < 30 && !m_fo; i++) sync_slot();
        chk("R3 overflow after reaching limit", ovf_flag, 1'b1);

        // new match value applies after the crossing
        sync_slot();
        wr(4'h3, 8'h03);
        m_fc = 1'b0; m_fo = 1'b0;
        commit(4'hB, 16'd3, 1'b1);
        wait_idle();
        for (int i = 0; i < 30 && !m_fc; i++) sync_slot();
        chk("R11 match flag with new value", cmp_flag, 1'b1);
        for (int i = 0; i < 6; i++) sync_slot();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule